// File: doc/BRIEF.md
# Climate Mode and Drive Controller

This block sits behind the front-panel logic of a room climate unit. It keeps the current operating mode, reads the measured room temperature and the user's target temperature, decides whether the room is too cold, too warm or acceptable, and turns that decision into a single request to the heater, the cooler or the dehumidifier. It raises at most one of these requests at a time.

The mode button steps through four modes in a fixed ring: standard, automatic, sleep, dehumidify, and then back to standard. Standard and sleep modes judge the room against the user target. Automatic mode ignores the target and uses a fixed comfort band. Dehumidify mode always asks for drying. A registered driver state machine holds the chosen request. Two conditions remove every request in the same cycle they appear: a faulty temperature reading, and the enable line from the shutdown timer going low.

Top module: `clim_drive_ctrl`

## Requirements
- R1: After reset the mode output reads standard (code 0) and heat, cool and dry requests are all low.
- R2: A cycle with both `tick` and `mode_btn` high advances the mode at that edge in the ring standard (0) → automatic (1) → sleep (2) → dehumidify (3) → standard (0).
- R3: A `mode_btn` pulse while `tick` is low does not change the mode.
- R4: In standard mode, one cycle after the inputs settle, room below target gives heat, room above target gives cool, and room equal to target gives no request.
- R5: Sleep mode classifies the room against the target exactly as standard mode does.
- R6: In automatic mode the target is ignored: room below `AUTO_LO` (17) gives heat, room above `AUTO_HI` (26) gives cool, and 17 to 26 inclusive gives no request.
- R7: In dehumidify mode the dry request is raised whatever the temperatures, and a dry request appears only in the cycle after the mode was dehumidify.
- R8: A room reading of all ones (8'hFF) marks a failed sensor. It raises cold and hot together, and all requests drop in that same cycle, in every mode.
- R9: With `run_en` low all requests are low in that same cycle, and the driver returns to no operation.
- R10: At most one of heat, cool and dry is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Control tick; a button press counts only while it is high |
| mode_btn | input | 1 | One-cycle mode button pulse |
| room_t | input | TW | Measured room temperature, unsigned °C; all ones marks a sensor fault |
| set_t | input | TW | User target temperature, unsigned °C |
| run_en | input | 1 | Enable from the shutdown timer |
| mode_o | output | 2 | Current mode: 0 standard, 1 automatic, 2 sleep, 3 dehumidify |
| heat_o | output | 1 | Heating request |
| cool_o | output | 1 | Cooling request |
| dry_o | output | 1 | Dehumidify request |

## Verification
A mode step and the driver's update happen at the same clock edge, so the driver still acts on the old mode for one cycle. The bench holds the temperatures steady across a press and judges the request only after the second edge, when the new mode's classification must be showing. The cutoff path can also coincide with a latched request. The bench puts the driver in heating or drying and then, between edges, applies the fault reading or drops the enable. It requires all requests to be low in that same cycle, before the state register has changed.

// File: rtl/clim_drive_ctrl.sv
module clim_drive_ctrl #(
  parameter int TW      = 8,
  parameter int AUTO_LO = 17,
  parameter int AUTO_HI = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_btn,
  input  logic [TW-1:0] room_t,
  input  logic [TW-1:0] set_t,
  input  logic          run_en,
  output logic [1:0]    mode_o,
  output logic          heat_o,
  output logic          cool_o,
  output logic          dry_o
);
  localparam logic [TW-1:0] BAD_READ = '1;
  localparam logic [TW-1:0] BAND_LO  = TW'(AUTO_LO);
  localparam logic [TW-1:0] BAND_HI  = TW'(AUTO_HI);

  typedef enum logic [1:0] {M_STD, M_AUTO, M_SLEEP, M_DRY} mode_t;
  typedef enum logic [1:0] {D_IDLE, D_HEAT, D_COOL, D_DRY} drv_t;

  mode_t mode;
  drv_t  drv, drv_nx;
  logic  cold, hot, wet, clash, allow;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                mode <= M_STD;
    else if (tick && mode_btn) mode <= mode_t'(mode + 2'd1);

  always_comb begin
    cold = 1'b0;
    hot  = 1'b0;
    wet  = 1'b0;
    case (mode)
      M_STD, M_SLEEP: begin
        cold = room_t < set_t;
        hot  = room_t > set_t;
      end
      M_AUTO: begin
        cold = room_t < BAND_LO;
        hot  = room_t > BAND_HI;
      end
      default: wet = 1'b1;
    endcase
    if (room_t == BAD_READ) begin
      cold = 1'b1;
      hot  = 1'b1;
    end
  end

  assign clash = cold && hot;
  assign allow = run_en && !clash;

  always_comb begin
    if (!allow)    drv_nx = D_IDLE;
    else if (cold) drv_nx = D_HEAT;
    else if (hot)  drv_nx = D_COOL;
    else if (wet)  drv_nx = D_DRY;
    else           drv_nx = D_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) drv <= D_IDLE;
    else        drv <= drv_nx;

  assign mode_o = mode;
  assign heat_o = allow && (drv == D_HEAT);
  assign cool_o = allow && (drv == D_COOL);
  assign dry_o  = allow && (drv == D_DRY);
endmodule

module clim_drive_ctrl_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          mode_btn,
  input logic [TW-1:0] room_t,
  input logic [TW-1:0] set_t,
  input logic          run_en,
  input logic [1:0]    mode_o,
  input logic          heat_o,
  input logic          cool_o,
  input logic          dry_o
);
  logic any_req;
  assign any_req = heat_o || cool_o || dry_o;

  AST_ONE_REQ:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0({heat_o, cool_o, dry_o})); // R10
  AST_MODE_STEP:  assert property (@(posedge clk) disable iff (!rst_n) (tick && mode_btn) |=> mode_o == $past(mode_o) + 2'd1); // R2
  AST_MODE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !(tick && mode_btn) |=> $stable(mode_o)); // R3
  AST_FAULT_OFF:  assert property (@(posedge clk) disable iff (!rst_n) (room_t == '1) |-> !any_req); // R8
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !run_en |-> !any_req); // R9
  AST_DRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) dry_o |-> $past(mode_o) == 2'd3); // R7
endmodule

bind clim_drive_ctrl clim_drive_ctrl_chk #(.TW(TW)) chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_btn(mode_btn),
  .room_t(room_t), .set_t(set_t), .run_en(run_en),
  .mode_o(mode_o), .heat_o(heat_o), .cool_o(cool_o), .dry_o(dry_o)
);

// File: tb/clim_drive_ctrl_test.sv
module clim_drive_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode_btn = 1'b0;
  logic [7:0] room_t = 8'd22;
  logic [7:0] set_t = 8'd22;
  logic       run_en = 1'b1;
  logic [1:0] mode_o;
  logic       heat_o, cool_o, dry_o;

  int checks = 0;
  int fails = 0;
  int m = 0;
  bit done = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clim_drive_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_btn(mode_btn),
    .room_t(room_t), .set_t(set_t), .run_en(run_en),
    .mode_o(mode_o), .heat_o(heat_o), .cool_o(cool_o), .dry_o(dry_o)
  );

  function automatic logic [4:0] model();
    logic h = 0, c = 0, d = 0;
    if (run_en && room_t != 8'hFF) begin
      case (m)
        0, 2: begin h = room_t < set_t; c = room_t > set_t; end
        1:    begin h = room_t < 8'd17; c = room_t > 8'd26; end
        default: d = 1;
      endcase
    end
    return {2'(m), h, c, d};
  endfunction

  task automatic push_exp(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  task automatic apply(input logic [7:0] r, input logic [7:0] s, input logic e,
                       input logic btn, input logic tk, input string tag);
    @(posedge clk); #2;
    room_t = r; set_t = s; run_en = e; mode_btn = btn; tick = tk;
    @(posedge clk); #2;
    if (btn && tk) m = (m + 1) % 4;
    mode_btn = 0; tick = 0;
    @(posedge clk); #1;
    push_exp(tag);
  endtask

  task automatic instant(input logic [7:0] r, input logic e, input string tag);
    @(posedge clk); #2;
    room_t = r; run_en = e;
    #1;
    checks++;
    if (heat_o || cool_o || dry_o) begin
      fails++;
      $display("FAIL %s same-cycle cutoff: got h/c/d=%b%b%b expected 000", tag, heat_o, cool_o, dry_o);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({mode_o, heat_o, cool_o, dry_o} !== e) begin
        fails++;
        $display("FAIL %s: got mode=%0d h/c/d=%b%b%b expected mode=%0d h/c/d=%b",
                 t, mode_o, heat_o, cool_o, dry_o, e[4:3], e[2:0]);
      end
      checks++;
      if ($countones({heat_o, cool_o, dry_o}) > 1) begin
        fails++;
        $display("FAIL R10: got h/c/d=%b%b%b expected at most one high", heat_o, cool_o, dry_o);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got no completion expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #1;
    push_exp("R1");
    // standard
    apply(8'd18, 8'd22, 1, 0, 0, "R4");
    apply(8'd30, 8'd22, 1, 0, 0, "R4");
    apply(8'd22, 8'd22, 1, 0, 0, "R4");
    apply(8'd15, 8'd22, 1, 1, 0, "R3");
    // automatic
    apply(8'd15, 8'd22, 1, 1, 1, "R2");
    apply(8'd20, 8'd40, 1, 0, 0, "R6");
    apply(8'd16, 8'd10, 1, 0, 0, "R6");
    apply(8'd17, 8'd30, 1, 0, 0, "R6");
    apply(8'd26, 8'd10, 1, 0, 0, "R6");
    apply(8'd27, 8'd40, 1, 0, 0, "R6");
    // sleep
    apply(8'd25, 8'd22, 1, 1, 1, "R5");
    apply(8'd20, 8'd22, 1, 0, 0, "R5");
    apply(8'd22, 8'd22, 1, 0, 0, "R5");
    // dehumidify
    apply(8'd40, 8'd22, 1, 1, 1, "R7");
    apply(8'd5,  8'd22, 1, 0, 0, "R7");
    apply(8'd40, 8'd22, 0, 0, 0, "R9");
    apply(8'd24, 8'd22, 1, 0, 0, "R7");
    instant(8'hFF, 1, "R8");
    apply(8'hFF, 8'd22, 1, 0, 0, "R8");
    // wrap to standard
    apply(8'd18, 8'd22, 1, 1, 1, "R2");
    instant(8'd18, 0, "R9");
    apply(8'd18, 8'd22, 1, 0, 0, "R4");
    instant(8'hFF, 1, "R8");
    apply(8'hFF, 8'd22, 1, 0, 0, "R8");
    apply(8'd40, 8'd22, 1, 0, 1, "R3");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule